// File: doc/BRIEF.md
# Acquisition Window and Start Control

This block sits on a camera pixel stream and decides which pixels reach the rest of the capture path. Frame and line enables arrive with the pixel data. The block counts pixels from each rising edge of the line enable and lines from each rising edge of the frame enable. It passes on only those pixels that fall inside a programmed rectangle, given as a start column, a width, a start row and a height. A passed pixel is marked when it is the first one of a frame and when it closes a line of the rectangle.

Capture is started in one of two ways. In software mode a start pulse captures a programmed number of frames and then stops; a count of zero means capture runs until an abort. In trigger mode the start pulse only arms the block. Capture then begins on the selected edge (rising or falling) of one chosen external trigger line. In both modes capture always begins at the next frame boundary, and the rectangle settings are taken only at frame starts. A sticky overrun flag reports when a line or frame ends before the rectangle does.

Top module: `acq_window_ctrl`

## Requirements
- R1: During and directly after reset, pix_vld, sof, eol, busy and overrun are all 0.
- R2: Pixel columns are numbered from 0, where column 0 is the pixel present in the cycle in which line_en rises. Column x is passed only when cfg_x0 <= x < cfg_x0 + cfg_xlen.
- R3: Rows are numbered from 0, where row 0 is the first line_en rise after frame_en rises. Row y is passed only when cfg_y0 <= y < cfg_y0 + cfg_ylen.
- R4: With cfg_mode = 0, a sw_start pulse while idle starts capture at the next rising edge of frame_en. A start that arrives while frame_en is already high skips the rest of that frame. After cfg_frames frames (cfg_frames != 0) busy returns to 0 and further frames are not passed.
- R5: With cfg_frames = 0, capture continues frame after frame until abort. Abort returns busy to 0, and no pixel is passed in the abort cycle or after it.
- R6: With cfg_mode = 1, sw_start only arms the block and busy becomes 1. Capture then waits for an edge on trig_in[cfg_trig_sel]: a rising edge when cfg_trig_fall = 0, a falling edge when it is 1. Frames and edges on other trigger lines are ignored until that edge occurs.
- R7: The window settings are sampled in the cycle in which frame_en rises. A change made later in the frame takes effect only from the next frame.
- R8: sof is 1 on the first pixel passed in each frame. eol is 1 on a passed pixel whose column equals cfg_x0 + cfg_xlen - 1.
- R9: If a line inside the row window ends before column cfg_x0 + cfg_xlen, or a frame ends before row cfg_y0 + cfg_ylen, the output is truncated and overrun becomes 1. It stays 1 until the next accepted sw_start clears it.
- R10: A passed pixel appears on pix_out with pix_vld = 1 exactly one clock after it is presented on pix_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_en | input | 1 | Frame enable from the camera |
| line_en | input | 1 | Line enable from the camera |
| pix_in | input | DW | Pixel data |
| trig_in | input | NTRIG | External trigger lines |
| cfg_mode | input | 1 | 0 software start, 1 trigger start |
| cfg_trig_sel | input | TSW | Index of the trigger line used |
| cfg_trig_fall | input | 1 | 1 selects the falling trigger edge |
| cfg_frames | input | FCW | Frames per capture, 0 = continuous |
| cfg_x0 | input | CW | First column of the window |
| cfg_xlen | input | CW | Window width in pixels |
| cfg_y0 | input | CW | First row of the window |
| cfg_ylen | input | CW | Window height in lines |
| sw_start | input | 1 | Start (software mode) or arm (trigger mode) pulse |
| abort | input | 1 | Stops capture and returns to idle |
| pix_out | output | DW | Gated pixel data |
| pix_vld | output | 1 | pix_out holds a passed pixel |
| sof | output | 1 | First passed pixel of a frame |
| eol | output | 1 | Last window pixel of a line |
| busy | output | 1 | Capture armed, waiting or running |
| overrun | output | 1 | Sticky window-truncation flag |

## Verification
Two cases are hard to reach from the ports. The first is a start that lands inside a frame. The bench raises frame_en by hand, pulses the start while the frame is open and streams lines, so that only the following frame must appear. The second is a window change that lands inside a frame. The bench rewrites cfg_x0 at the start of the second line of a two-frame capture and expects the old column range in that frame and the new one in the next. Trigger selection is exercised by toggling a non-selected line before the selected one, with a whole frame sent in between that must produce nothing.

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl #(
  parameter int DW    = 8,
  parameter int CW    = 12,
  parameter int FCW   = 8,
  parameter int NTRIG = 4,
  localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic             line_en,
  input  logic [DW-1:0]    pix_in,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             cfg_mode,
  input  logic [TSW-1:0]   cfg_trig_sel,
  input  logic             cfg_trig_fall,
  input  logic [FCW-1:0]   cfg_frames,
  input  logic [CW-1:0]    cfg_x0,
  input  logic [CW-1:0]    cfg_xlen,
  input  logic [CW-1:0]    cfg_y0,
  input  logic [CW-1:0]    cfg_ylen,
  input  logic             sw_start,
  input  logic             abort,
  output logic [DW-1:0]    pix_out,
  output logic             pix_vld,
  output logic             sof,
  output logic             eol,
  output logic             busy,
  output logic             overrun
);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_WAIT, S_CAP, S_DONE} st_t;
  st_t st;

  logic             fe_q, le_q;
  logic [NTRIG-1:0] trig_q;
  logic [CW-1:0]    xnext, ynext, yline;
  logic [CW-1:0]    wx0, wxl, wy0, wyl;
  logic [FCW-1:0]   frm_lim, frm_cnt;
  logic             first_pend;

  wire f_rise = frame_en & ~fe_q;
  wire f_fall = ~frame_en & fe_q;
  wire l_rise = line_en & ~le_q;
  wire l_fall = ~line_en & le_q;

  wire t_now  = trig_in[cfg_trig_sel];
  wire t_prev = trig_q[cfg_trig_sel];
  wire t_edge = cfg_trig_fall ? (t_prev & ~t_now) : (~t_prev & t_now);

  wire frame_go = (st == S_WAIT) & f_rise;
  wire cap      = (st == S_CAP) | frame_go;

  wire [CW-1:0] ex0 = frame_go ? cfg_x0   : wx0;
  wire [CW-1:0] exl = frame_go ? cfg_xlen : wxl;
  wire [CW-1:0] ey0 = frame_go ? cfg_y0   : wy0;
  wire [CW-1:0] eyl = frame_go ? cfg_ylen : wyl;
  wire [CW:0]   xend = {1'b0, ex0} + {1'b0, exl};
  wire [CW:0]   yend = {1'b0, ey0} + {1'b0, eyl};

  wire [CW-1:0] ybase = f_rise ? '0 : ynext;
  wire [CW-1:0] x_now = l_rise ? '0 : xnext;
  wire [CW-1:0] y_now = l_rise ? ybase : yline;

  wire in_x = (x_now >= ex0) && ({1'b0, x_now} < xend);
  wire in_y = (y_now >= ey0) && ({1'b0, y_now} < yend);
  wire pass = cap & frame_en & line_en & in_x & in_y & ~abort;

  wire line_in_y = (yline >= wy0) && ({1'b0, yline} < yend);
  wire ovr_h = (st == S_CAP) & l_fall & line_in_y & ({1'b0, xnext} < xend);
  wire ovr_v = (st == S_CAP) & f_fall & ({1'b0, ynext} < yend);

  assign busy = (st == S_ARMED) | (st == S_WAIT) | (st == S_CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fe_q <= 1'b0; le_q <= 1'b0; trig_q <= '0;
      xnext <= '0; ynext <= '0; yline <= '0;
      wx0 <= '0; wxl <= '0; wy0 <= '0; wyl <= '0;
      frm_lim <= '0; frm_cnt <= '0; first_pend <= 1'b0;
      pix_out <= '0; pix_vld <= 1'b0; sof <= 1'b0; eol <= 1'b0;
      overrun <= 1'b0;
    end else begin
      fe_q <= frame_en;
      le_q <= line_en;
      trig_q <= trig_in;
      if (line_en) xnext <= x_now + 1'b1;
      if (l_rise) begin
        ynext <= ybase + 1'b1;
        yline <= ybase;
      end else if (f_rise) begin
        ynext <= '0;
      end
      if (frame_go) begin
        wx0 <= cfg_x0; wxl <= cfg_xlen; wy0 <= cfg_y0; wyl <= cfg_ylen;
        first_pend <= ~pass;
      end else if (pass) begin
        first_pend <= 1'b0;
      end
      pix_vld <= pass;
      sof <= pass & (frame_go | first_pend);
      eol <= pass & (({1'b0, x_now} + 1'b1) == xend);
      if (pass) pix_out <= pix_in;
      if (ovr_h | ovr_v) overrun <= 1'b1;

      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (sw_start) begin
            st <= cfg_mode ? S_ARMED : S_WAIT;
            frm_lim <= cfg_frames;
            frm_cnt <= '0;
            overrun <= 1'b0;
          end
          S_ARMED: if (t_edge) st <= S_WAIT;
          S_WAIT:  if (f_rise) st <= S_CAP;
          S_CAP: if (f_fall) begin
            frm_cnt <= frm_cnt + 1'b1;
            if (frm_lim != '0 && FCW'(frm_cnt + 1'b1) == frm_lim) st <= S_DONE;
            else st <= S_WAIT;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_sof_marks_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> pix_vld);
  p_eol_marks_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> pix_vld);
  p_pass_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(busy));
  p_abort_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !pix_vld));
  p_start_accepted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && sw_start && !abort) |=> busy);
  p_armed_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && !t_edge && !abort) |=> (st == S_ARMED));
  p_frame_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && frm_lim != '0) |-> (frm_cnt < frm_lim));

endmodule

// File: tb/acq_window_ctrl_tb_top.sv
module acq_window_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, CW = 12, FCW = 8, NTRIG = 4, TSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_en = 0, line_en = 0;
  logic [DW-1:0] pix_in = '0;
  logic [NTRIG-1:0] trig_in = '0;
  logic cfg_mode = 0, cfg_trig_fall = 0;
  logic [TSW-1:0] cfg_trig_sel = '0;
  logic [FCW-1:0] cfg_frames = '0;
  logic [CW-1:0] cfg_x0 = '0, cfg_xlen = '0, cfg_y0 = '0, cfg_ylen = '0;
  logic sw_start = 0, abort = 0;
  logic [DW-1:0] pix_out;
  logic pix_vld, sof, eol, busy, overrun;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int chg_line = -1, chg_x0 = 0;
  int mark_y = -1, mark_x = -1, drv_cyc = -1, sof_cyc = -1;
  logic [DW+1:0] gotq[$];
  logic [DW+1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  acq_window_ctrl #(.DW(DW), .CW(CW), .FCW(FCW), .NTRIG(NTRIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .line_en(line_en),
    .pix_in(pix_in), .trig_in(trig_in), .cfg_mode(cfg_mode),
    .cfg_trig_sel(cfg_trig_sel), .cfg_trig_fall(cfg_trig_fall),
    .cfg_frames(cfg_frames), .cfg_x0(cfg_x0), .cfg_xlen(cfg_xlen),
    .cfg_y0(cfg_y0), .cfg_ylen(cfg_ylen), .sw_start(sw_start), .abort(abort),
    .pix_out(pix_out), .pix_vld(pix_vld), .sof(sof), .eol(eol),
    .busy(busy), .overrun(overrun));

  always @(negedge clk) if (rst_n && pix_vld) begin
    gotq.push_back({sof, eol, pix_out});
    if (sof && sof_cyc < 0) sof_cyc = cyc;
  end

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_q(string req);
    chk(req, "pixel count", gotq.size(), expq.size());
    for (int i = 0; i < gotq.size() && i < expq.size(); i++)
      chk(req, $sformatf("entry %0d {sof,eol,pix}", i), int'(gotq[i]), int'(expq[i]));
    gotq.delete(); expq.delete();
  endtask

  task automatic exp_frame(int nl, int np, int x0, int xl, int y0, int yl);
    bit first = 1;
    for (int y = y0; y < y0 + yl && y < nl; y++)
      for (int x = x0; x < x0 + xl && x < np; x++) begin
        expq.push_back({first, (x == x0 + xl - 1), DW'(y*16 + x)});
        first = 0;
      end
  endtask

  task automatic send_frame(int nl, int np);
    frame_en = 1; step();
    for (int y = 0; y < nl; y++) begin
      if (y == chg_line) cfg_x0 = CW'(chg_x0);
      for (int x = 0; x < np; x++) begin
        line_en = 1; pix_in = DW'(y*16 + x);
        if (y == mark_y && x == mark_x) drv_cyc = cyc;
        step();
      end
      line_en = 0; step(); step();
    end
    frame_en = 0; step(); step(); step();
  endtask

  task automatic set_win(int x0, int xl, int y0, int yl);
    cfg_x0 = CW'(x0); cfg_xlen = CW'(xl); cfg_y0 = CW'(y0); cfg_ylen = CW'(yl);
  endtask

  task automatic pulse_start(); sw_start = 1; step(); sw_start = 0; endtask

  task automatic t_reset();
    chk("R1", "pix_vld", pix_vld, 0); chk("R1", "sof", sof, 0);
    chk("R1", "eol", eol, 0); chk("R1", "busy", busy, 0);
    chk("R1", "overrun", overrun, 0);
  endtask

  task automatic t_single();
    cfg_mode = 0; cfg_frames = 1; set_win(2, 3, 1, 2);
    mark_y = 1; mark_x = 2; sof_cyc = -1;
    pulse_start(); step();
    chk("R4", "busy after start", busy, 1);
    exp_frame(4, 6, 2, 3, 1, 2);
    send_frame(4, 6);
    cmp_q("R2_R3_R8");
    chk("R10", "one-cycle latency", sof_cyc - drv_cyc, 1);
    chk("R4", "busy after last frame", busy, 0);
    chk("R9", "no overrun inside frame", overrun, 0);
    mark_y = -1;
  endtask

  task automatic t_multi();
    cfg_frames = 2; set_win(0, 2, 0, 1);
    pulse_start();
    exp_frame(2, 3, 0, 2, 0, 1); exp_frame(2, 3, 0, 2, 0, 1);
    send_frame(2, 3); send_frame(2, 3);
    chk("R4", "busy after two frames", busy, 0);
    send_frame(2, 3);
    cmp_q("R4");
  endtask

  task automatic t_midframe();
    cfg_frames = 1; set_win(0, 3, 0, 2);
    frame_en = 1; step();
    pulse_start();
    for (int y = 0; y < 2; y++) begin
      for (int x = 0; x < 4; x++) begin line_en = 1; pix_in = DW'(8'hE0 + x); step(); end
      line_en = 0; step();
    end
    frame_en = 0; step(); step();
    chk("R4", "mid-frame start produced nothing", gotq.size(), 0);
    exp_frame(3, 4, 0, 3, 0, 2);
    send_frame(3, 4);
    cmp_q("R4");
  endtask

  task automatic t_trig_rise();
    cfg_mode = 1; cfg_trig_sel = 2; cfg_trig_fall = 0; cfg_frames = 1;
    set_win(1, 2, 0, 2);
    pulse_start(); step();
    chk("R6", "armed busy", busy, 1);
    send_frame(2, 4);
    chk("R6", "frame before trigger ignored", gotq.size(), 0);
    trig_in[1] = 1; step(); trig_in[1] = 0; step();
    send_frame(2, 4);
    chk("R6", "other trigger line ignored", gotq.size(), 0);
    trig_in[2] = 1; step(); trig_in[2] = 0; step();
    exp_frame(2, 4, 1, 2, 0, 2);
    send_frame(2, 4);
    cmp_q("R6");
    chk("R6", "idle after triggered frame", busy, 0);
  endtask

  task automatic t_trig_fall();
    cfg_trig_fall = 1; trig_in = '1; step(); step();
    pulse_start(); step();
    send_frame(2, 4);
    chk("R6", "no falling edge yet", gotq.size(), 0);
    trig_in[2] = 0; step();
    exp_frame(2, 4, 1, 2, 0, 2);
    send_frame(2, 4);
    cmp_q("R6");
    trig_in = '0; cfg_mode = 0; cfg_trig_fall = 0;
  endtask

  task automatic t_cont();
    cfg_frames = 0; set_win(0, 2, 1, 1);
    pulse_start();
    for (int f = 0; f < 3; f++) begin exp_frame(2, 3, 0, 2, 1, 1); send_frame(2, 3); end
    cmp_q("R5");
    chk("R5", "still busy after 3 frames", busy, 1);
    abort = 1; step(); abort = 0;
    chk("R5", "idle after abort", busy, 0);
    set_win(0, 8, 0, 1);
    pulse_start();
    frame_en = 1; step();
    line_en = 1; pix_in = 8'h00; step(); pix_in = 8'h01; step();
    abort = 1; pix_in = 8'h02; step(); abort = 0;
    pix_in = 8'h03; step(); pix_in = 8'h04; step();
    line_en = 0; step(); frame_en = 0; step(); step();
    expq.push_back({1'b1, 1'b0, 8'h00}); expq.push_back({1'b0, 1'b0, 8'h01});
    cmp_q("R5");
    chk("R5", "idle after mid-frame abort", busy, 0);
  endtask

  task automatic t_cfgchg();
    cfg_frames = 2; set_win(1, 2, 0, 2);
    pulse_start();
    chg_line = 1; chg_x0 = 3;
    exp_frame(2, 6, 1, 2, 0, 2);
    send_frame(2, 6);
    chg_line = -1;
    exp_frame(2, 6, 3, 2, 0, 2);
    send_frame(2, 6);
    cmp_q("R7");
  endtask

  task automatic t_overrun();
    cfg_frames = 1; set_win(4, 5, 0, 2);
    pulse_start();
    exp_frame(3, 6, 4, 5, 0, 2);
    send_frame(3, 6);
    cmp_q("R9");
    chk("R9", "horizontal overrun", overrun, 1);
    set_win(0, 2, 2, 5);
    pulse_start(); step();
    chk("R9", "cleared by start", overrun, 0);
    exp_frame(4, 3, 0, 2, 2, 5);
    send_frame(4, 3);
    cmp_q("R9");
    chk("R9", "vertical overrun", overrun, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step(); step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_single();
    t_multi();
    t_midframe();
    t_trig_rise();
    t_trig_fall();
    t_cont();
    t_cfgchg();
    t_overrun();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule